// File: doc/BRIEF.md
# Parity-Appending Serial Byte Transmitter

This block turns a parallel byte into an asynchronous serial character. A host places a byte on `dataIn`, chooses the parity sense on `oddSel`, and pulls the active-low strobe `writeN` low. The strobe is not related to the block clock. The block passes the strobe through a synchroniser and qualifies its length. On acceptance it captures the byte and the parity sense together. It then sends an eleven-bit character at a bit rate derived from the master clock.

Each character begins with a low start bit. The eight data bits follow, least significant first, then the parity bit, then a high stop bit. `busy` is high for the whole character so that the host does not write over it. Outside a character the line rests high. The default timing assumes a 32768 Hz master clock divided by 18, which gives roughly 1800 bit/s.

Top module: `serial_parity_tx`

## Requirements
- R1: While the synchronous active-low reset `rstN` is sampled low, `serialOut` is 1 and `busy` is 0 after the next clock edge.
- R2: A character is the serial sequence 0 (start), `dataIn[0]` through `dataIn[7]`, parity, then 1 (stop). Each bit is driven for exactly BIT_CLKS (default 18) clocks, and `serialOut` changes only at bit boundaries.
- R3: The parity bit makes the number of ones across the eight data bits and the parity bit even when the captured `oddSel` is 0, and odd when it is 1.
- R4: A strobe is accepted only if `writeN` stays low for at least MIN_LOW (default 4) consecutive clocks. A low pulse of 3 clocks or fewer starts no character.
- R5: `busy` rises together with the start bit. It stays high for exactly 11 × BIT_CLKS clocks (198 by default), so it falls only after the stop bit has lasted a full bit period.
- R6: `dataIn` and `oddSel` are captured on the acceptance edge. Later changes to either input, including a parity-select change mid-character, leave the character in flight unchanged.
- R7: A strobe that occurs while `busy` is high starts no character and does not disturb the current one. A single strobe held low past the end of its own character starts only one character, because a new one needs `writeN` to be seen high while idle first.
- R8: After the stop bit, and at every other time `busy` is low, `serialOut` is 1.
- R9: Reset asserted in the middle of a character aborts it. One clock later `serialOut` is 1 and `busy` is 0, and the next accepted strobe sends a complete character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| writeN | input | 1 | Asynchronous active-low write strobe |
| dataIn | input | 8 | Byte to transmit |
| oddSel | input | 1 | Parity sense: 0 even, 1 odd |
| serialOut | output | 1 | Registered serial line, idle high |
| busy | output | 1 | High while a character is being sent |

## Verification
The bench drives strobes right at the qualification limit: 4 clocks must be accepted and 3 must be rejected. A design with an off-by-one qualifier would either drop valid writes or treat glitches as writes. After every acceptance it flips both `dataIn` and `oddSel`. A design that reads them live instead of capturing them sends corrupted data bits or a wrong parity bit.

The bench writes during a character and also holds a single strobe low across the end of its own character. A design that does not block writes while busy would restart the frame. A design that does not re-arm on a high level would send a second, unrequested character. Finally, the bench resets in mid-character. A design whose reset misses the counters would leave `busy` stuck or would send a truncated next character.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  // Strobes from the control side to the frame datapath
  typedef struct packed {
    logic load;   // capture byte and parity, start bit onto the line
    logic shift;  // advance to the next bit of the frame
  } txStrobe_t;

endpackage

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              oddSel,
  output logic              serialOut
);

  localparam int FRAME_W = DATA_W + 3;

  logic [FRAME_W-1:0] frameQ;
  logic               parityBit;

  // Parity bit makes total ones even (oddSel=0) or odd (oddSel=1)
  assign parityBit = (^dataIn) ^ oddSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '1;
    end else if (strobe.load) begin
      frameQ <= {1'b1, parityBit, dataIn, 1'b0};
    end else if (strobe.shift) begin
      frameQ <= {1'b1, frameQ[FRAME_W-1:1]};
    end
  end

  // Line is the low end of the frame register: a flop output, glitch free
  assign serialOut = frameQ[0];

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_CLKS    = 18,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      writeN,
  output logic      busy,
  output txStrobe_t strobe
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int TICK_W  = $clog2(BIT_CLKS);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int LOW_W   = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLow;
  logic [LOW_W-1:0]       lowCnt;
  logic                   armed;
  logic                   accept;
  logic [TICK_W-1:0]      tick;
  logic [IDX_W-1:0]       bitIdx;
  logic                   busyQ;
  logic                   lastTick;
  logic                   lastBit;

  // Strobe synchroniser, idles high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], writeN};
  end

  assign syncLow = !syncQ[SYNC_STAGES-1];

  // Re-arm only after a high level is seen while idle
  always_ff @(posedge clk) begin
    if (!rstN)                    armed <= 1'b0;
    else if (accept)              armed <= 1'b0;
    else if (!syncLow && !busyQ)  armed <= 1'b1;
  end

  // Count consecutive low samples of an armed strobe
  always_ff @(posedge clk) begin
    if (!rstN || !syncLow || busyQ || !armed) lowCnt <= '0;
    else if (lowCnt != LOW_W'(MIN_LOW))       lowCnt <= lowCnt + LOW_W'(1);
  end

  assign accept = syncLow && armed && !busyQ && (lowCnt == LOW_W'(MIN_LOW - 1));

  assign lastTick = (tick == TICK_W'(BIT_CLKS - 1));
  assign lastBit  = (bitIdx == IDX_W'(FRAME_W - 1));

  // Bit timer restarts on acceptance so the start bit is a full period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      tick   <= '0;
      bitIdx <= '0;
    end else if (accept) begin
      busyQ  <= 1'b1;
      tick   <= '0;
      bitIdx <= '0;
    end else if (busyQ) begin
      if (lastTick) begin
        tick <= '0;
        if (lastBit) busyQ  <= 1'b0;
        else         bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        tick <= tick + TICK_W'(1);
      end
    end
  end

  assign busy         = busyQ;
  assign strobe.load  = accept;
  assign strobe.shift = busyQ && lastTick;

endmodule

// File: rtl/serial_parity_tx.sv
module serial_parity_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_CLKS    = 18,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              oddSel,
  output logic              serialOut,
  output logic              busy
);

  txStrobe_t strobe;

  serial_tx_ctrl #(
    .DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS),
    .SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .writeN(writeN), .busy(busy), .strobe(strobe)
  );

  serial_tx_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dataIn(dataIn), .oddSel(oddSel), .serialOut(serialOut)
  );

endmodule

// File: rtl/serial_parity_tx_checker.sv
module serial_parity_tx_checker #(
  parameter int DATA_W   = 8,
  parameter int BIT_CLKS = 18
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic serialOut
);

  localparam int FRAME_LEN = (DATA_W + 3) * BIT_CLKS;
  localparam int PH_W      = $clog2(BIT_CLKS);
  localparam int LEN_W     = $clog2(FRAME_LEN + 1);

  logic [PH_W-1:0]  phaseQ;
  logic [LEN_W-1:0] lenQ;
  logic             wasRstQ;

  always_ff @(posedge clk) begin
    if (!rstN || !busy)                    phaseQ <= '0;
    else if (phaseQ == PH_W'(BIT_CLKS-1))  phaseQ <= '0;
    else                                   phaseQ <= phaseQ + PH_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !busy) lenQ <= '0;
    else                lenQ <= lenQ + LEN_W'(1);
  end

  always_ff @(posedge clk) wasRstQ <= !rstN;

  // R5: character opens with the start bit
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !serialOut);

  // R2: line holds between bit boundaries
  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && phaseQ != '0) |-> $stable(serialOut));

  // R5: busy lasts the whole eleven-bit character
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (lenQ == LEN_W'(FRAME_LEN)));

  // R8: idle line is high
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serialOut);

  // R1, R9: one clock after a reset sample the outputs are at rest
  always_ff @(posedge clk) begin
    if (wasRstQ) begin
      p_reset_rest_r9: assert (serialOut && !busy);
    end
  end

endmodule

bind serial_parity_tx serial_parity_tx_checker #(
  .DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS)
) i_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .serialOut(serialOut)
);

// File: tb/test_serial_parity_tx.sv
module test_serial_parity_tx;

  localparam int DATA_W    = 8;
  localparam int BIT_CLKS  = 18;
  localparam int FRAME_W   = DATA_W + 3;
  localparam int FRAME_LEN = FRAME_W * BIT_CLKS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              writeN;
  logic [DATA_W-1:0] dataIn;
  logic              oddSel;
  logic              serialOut;
  logic              busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit abortFrame = 1'b0;
  logic [FRAME_W-1:0] expQ[$];

  serial_parity_tx i_serial_parity_tx (
    .clk(clk), .rstN(rstN), .writeN(writeN), .dataIn(dataIn),
    .oddSel(oddSel), .serialOut(serialOut), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] makeFrame(input logic [DATA_W-1:0] d,
                                                  input logic odd);
    return {1'b1, (^d) ^ odd, d, 1'b0};
  endfunction

  // Driver: push expected frame, hold strobe, scramble inputs once captured
  task automatic sendByte(input logic [DATA_W-1:0] d, input logic odd,
                          input int lowClks, input bit push);
    int n = 0;
    bit scrambled = 1'b0;
    if (push) expQ.push_back(makeFrame(d, odd));
    dataIn = d;
    oddSel = odd;
    writeN = 1'b0;
    while (n < lowClks || !scrambled) begin
      @(negedge clk);
      n++;
      if (n == lowClks) writeN = 1'b1;
      if (busy && !scrambled) begin
        dataIn = ~d;          // R6: inputs change after capture
        oddSel = ~odd;
        scrambled = 1'b1;
      end
      if (n > 400) scrambled = 1'b1;
    end
  endtask

  task automatic pulse(input logic [DATA_W-1:0] d, input int lowClks);
    dataIn = d;
    writeN = 1'b0;
    repeat (lowClks) @(negedge clk);
    writeN = 1'b1;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    bit sawBusy = 1'b0;
    bit sawLow = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (busy) sawBusy = 1'b1;
      if (!serialOut) sawLow = 1'b1;
    end
    check(!sawBusy, req, "no character started", sawBusy, 0);
    check(!sawLow, req, "line stayed high", sawLow, 0);
  endtask

  // Monitor / scoreboard
  initial begin
    logic [FRAME_W-1:0] expF;
    int k;
    forever begin
      @(negedge clk);
      if (rstN && busy) begin
        if (abortFrame) begin
          while (busy) @(negedge clk);
        end else if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected character", 1, 0);
          while (busy) @(negedge clk);
        end else begin
          expF = expQ.pop_front();
          check(serialOut == 1'b0, "R5", "start bit with busy rise", serialOut, 0);
          k = 0;
          while (busy) begin
            if ((k % BIT_CLKS) == BIT_CLKS / 2 && (k / BIT_CLKS) < FRAME_W) begin
              if ((k / BIT_CLKS) == FRAME_W - 2)
                check(serialOut == expF[k / BIT_CLKS], "R3", "parity bit",
                      serialOut, expF[k / BIT_CLKS]);
              else if ((k / BIT_CLKS) == 0 || (k / BIT_CLKS) == FRAME_W - 1)
                check(serialOut == expF[k / BIT_CLKS], "R2", "start/stop bit",
                      serialOut, expF[k / BIT_CLKS]);
              else
                check(serialOut == expF[k / BIT_CLKS], "R2 R6", "data bit",
                      serialOut, expF[k / BIT_CLKS]);
            end
            k++;
            @(negedge clk);
          end
          check(k == FRAME_LEN, "R5", "busy length", k, FRAME_LEN);
          check(serialOut == 1'b1, "R8", "line after stop", serialOut, 1);
        end
      end
    end
  end

  // Stimulus
  initial begin
    rstN = 1'b0;
    writeN = 1'b1;
    dataIn = '0;
    oddSel = 1'b0;
    repeat (3) @(negedge clk);
    check(serialOut == 1'b1, "R1", "line in reset", serialOut, 1);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3: several bytes, both parity senses
    sendByte(8'h96, 1'b0, 6, 1'b1); waitIdle();
    sendByte(8'hE3, 1'b1, 4, 1'b1); waitIdle();   // R4: minimum length
    sendByte(8'h00, 1'b1, 5, 1'b1); waitIdle();
    sendByte(8'hFF, 1'b0, 6, 1'b1); waitIdle();
    sendByte(8'h0E, 1'b1, 7, 1'b1); waitIdle();

    // R4: three-clock pulse is rejected
    pulse(8'h81, 3);
    expectQuiet(40, "R4");

    // R7: write during a character is ignored
    sendByte(8'h5A, 1'b0, 6, 1'b1);
    repeat (40) @(negedge clk);
    pulse(8'hC3, 8);
    waitIdle();
    expectQuiet(40, "R7");

    // R7: one long strobe across the end of its own character
    sendByte(8'hA5, 1'b1, 260, 1'b1);
    waitIdle();
    expectQuiet(40, "R7");

    // R9: reset mid-character, then recover
    abortFrame = 1'b1;
    sendByte(8'h77, 1'b0, 6, 1'b0);
    repeat (50) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(serialOut == 1'b1, "R9", "line after mid-frame reset", serialOut, 1);
    check(busy == 1'b0, "R9", "busy after mid-frame reset", busy, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    abortFrame = 1'b0;
    repeat (5) @(negedge clk);
    sendByte(8'h3C, 1'b0, 6, 1'b1); waitIdle();

    check(expQ.size() == 0, "R7", "characters left unsent", expQ.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule